// File: doc/BRIEF.md
# Ethernet Transmit Auto-Pad Inserter

This block sits in the transmit byte path, between the frame buffer and the serializer. It accepts frame bytes from the destination address through the end of the payload, with a marker on the final byte, and forwards them unchanged to the line side. It keeps a running count of the bits placed on the wire. That count starts from the 64 preamble/SFD bits, which are counted here but generated elsewhere. When a frame ends short of the 544-bit mark, zero bytes are inserted until the mark is reached, and a CRC-32 frame check sequence follows them.

Two configuration inputs choose between automatic padding and FCS insertion. Both are captured only while the transmitter enable is low, and both reset to off. A padded frame always carries an FCS, whatever the FCS setting. The payload's own length/type field plays no part in the pad decision. The bit count alone decides it. Both sides use valid/ready handshakes. The output marks the last byte of each frame.

Top module: `eth_tx_padder`

## Requirements
- R1: After reset, padding and FCS insertion are both off until the transmitter enable goes low. With no input, out_valid is 0, and in_ready follows out_ready.
- R2: With padding on, a frame of N data bytes with 64 + 8*N < 544 gets exactly 60 - N pad bytes. A frame of 60 or more bytes gets none.
- R3: Pad bytes are 00h. They are emitted after the last data byte and before the FCS, and no input byte is consumed while they are emitted.
- R4: A padded frame is always followed by the 4-byte FCS, even when FCS insertion is off.
- R5: An unpadded frame passes through byte for byte. It is followed by the FCS only when FCS insertion is on. Without an FCS, out_last is set on the last data byte.
- R6: The FCS is the reflected CRC-32 (polynomial EDB88320h, initial value FFFFFFFFh, result complemented) over the data and pad bytes. It is sent least significant byte first, and out_last is set on its fourth byte.
- R7: cfg_pad_en and cfg_fcs_en are captured on each clock edge where tx_enable is 0. Changes made while tx_enable is 1 have no effect on the frames sent.
- R8: The contents of bytes 12 and 13 (the length/type field) do not change the number of pad bytes.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last are held, and no input byte is consumed beyond the one on offer.
- R10: A padded minimum frame is 64 bytes long including the FCS, which is 576 bits together with the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmitter enabled; configuration is frozen while 1 |
| cfg_pad_en | input | 1 | Request automatic padding |
| cfg_fcs_en | input | 1 | Request FCS insertion on unpadded frames |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last data byte of the frame |
| in_ready | output | 1 | Input byte accepted when in_valid is also 1 |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (data, pad or FCS) |
| out_last | output | 1 | Output byte is the last byte of the frame |
| out_ready | input | 1 | Line side accepts the output byte |

## Verification
The bench builds the block with its default parameters: a 64-bit preamble and a 64-byte minimum frame, which places the pad threshold at 544 bits, or 60 data bytes. Frame lengths from 1 to 90 bytes fall on both sides of that threshold and land exactly on it. They cover single-byte frames that need 59 pad bytes and frames of exactly 59, 60 and 61 bytes. Random gaps on the input and back-pressure on the output exercise the handshake hold, including stalls in the middle of padding and FCS.

// File: rtl/eth_pad_pkg.sv
// Shared types and the CRC-32 byte step for the transmit auto-pad inserter.
// Assumes the reflected IEEE 802.3 CRC-32, with bytes entering LSB first.
package eth_pad_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } pad_state_e;

    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    // Advances a reflected CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ data[b];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_pad_bitcnt.sv
// Counts the bits a frame has placed on the wire, starting from the preamble.
// The count saturates at the pad threshold and restarts when a frame completes.
// Assumes that frame_done and byte_sent may occur in the same cycle, in which
// case the restart wins.
module eth_pad_bitcnt #(
    parameter int PREAMBLE_BITS = 64,
    parameter int THRESH_BITS   = 544,
    parameter int BYTE_BITS     = 8,
    parameter int CNT_W         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_sent,
    input  logic             frame_done,
    output logic             reach_next,
    output logic [CNT_W-1:0] bit_cnt
);

    logic [CNT_W:0] sum_next;

    // The sum after one more byte, one bit wider so that it cannot wrap.
    always_comb begin
        sum_next   = {1'b0, bit_cnt} + (CNT_W+1)'(BYTE_BITS);
        reach_next = (sum_next >= (CNT_W+1)'(THRESH_BITS));
    end

    // Bit counter: preamble preset, saturating increment per sent byte.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_done)
            bit_cnt <= CNT_W'(PREAMBLE_BITS);
        else if (byte_sent)
            bit_cnt <= reach_next ? CNT_W'(THRESH_BITS) : sum_next[CNT_W-1:0];
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt >= CNT_W'(PREAMBLE_BITS)) && (bit_cnt <= CNT_W'(THRESH_BITS))); // R10

endmodule

// File: rtl/eth_pad_crc.sv
// CRC-32 accumulator over the data and pad bytes of one frame.
// Holds its value while the FCS bytes are sent, and reloads when a frame ends.
module eth_pad_crc
    import eth_pad_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_take,
    input  logic [7:0]  byte_in,
    input  logic        frame_done,
    output logic [31:0] fcs_value
);

    logic [31:0] crc_q;

    // CRC register: reload at the frame boundary, otherwise fold in each byte.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_done)
            crc_q <= CRC_INIT;
        else if (byte_take)
            crc_q <= crc32_step(crc_q, byte_in);
    end

    // The transmitted FCS is the complemented register.
    always_comb fcs_value = ~crc_q;

endmodule

// File: rtl/eth_pad_ctrl.sv
// Sequencer for the pad inserter: data pass-through, zero padding, FCS bytes.
// Captures the configuration only while the transmitter is disabled.
// Assumes that the input follows valid/ready rules and holds a byte it has offered.
module eth_pad_ctrl
    import eth_pad_pkg::*;
#(
    parameter int FCS_BYTES = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_enable,
    input  logic             cfg_pad_en,
    input  logic             cfg_fcs_en,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    input  logic             reach_next,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             byte_sent,
    output logic             frame_done,
    output pad_state_e       state,
    output logic [IDX_W-1:0] fcs_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

    pad_state_e       state_d;
    logic [IDX_W-1:0] idx_d;
    logic             pad_en_q;
    logic             fcs_en_q;
    logic             need_pad;
    logic             hs;

    // Configuration capture: reset to off, and sampled only while transmit is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_en_q <= 1'b0;
            fcs_en_q <= 1'b0;
        end else if (!tx_enable) begin
            pad_en_q <= cfg_pad_en;
            fcs_en_q <= cfg_fcs_en;
        end
    end

    // Handshake signals and frame-end decode for the current state.
    always_comb begin
        need_pad  = pad_en_q && !reach_next;
        out_valid = (state == ST_DATA) ? in_valid : 1'b1;
        in_ready  = (state == ST_DATA) && out_ready;
        hs        = out_valid && out_ready;
        unique case (state)
            ST_DATA: out_last = in_last && !need_pad && !fcs_en_q;
            ST_FCS:  out_last = (fcs_idx == LAST_IDX);
            default: out_last = 1'b0;
        endcase
        byte_sent  = hs && (state != ST_FCS);
        frame_done = hs && out_last;
    end

    // Next state: padding takes priority over the FCS-only path at the end of data.
    always_comb begin
        state_d = state;
        idx_d   = fcs_idx;
        if (hs) begin
            unique case (state)
                ST_DATA: if (in_last) begin
                    if (need_pad)      state_d = ST_PAD;
                    else if (fcs_en_q) state_d = ST_FCS;
                end
                ST_PAD: if (reach_next) state_d = ST_FCS;
                ST_FCS: begin
                    if (fcs_idx == LAST_IDX) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                    end else begin
                        idx_d = fcs_idx + IDX_W'(1);
                    end
                end
                default: state_d = ST_DATA;
            endcase
        end
    end

    // State and FCS byte index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_DATA;
            fcs_idx <= '0;
        end else begin
            state   <= state_d;
            fcs_idx <= idx_d;
        end
    end

    AST_PAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> pad_en_q); // R2
    AST_NO_TAKE_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> !in_ready); // R3
    AST_IDX_ONLY_IN_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        (fcs_idx != '0) |-> (state == ST_FCS)); // R6
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable |=> ($stable(pad_en_q) && $stable(fcs_en_q))); // R7

endmodule

// File: rtl/eth_tx_padder.sv
// Transmit auto-pad inserter. Passes frame bytes through and appends zero pad
// bytes until the 544-bit wire count, preamble included, is reached. Then
// appends the CRC-32 FCS: always on a padded frame, otherwise only when
// FCS insertion is enabled.
// Assumes that the preamble is generated downstream but counted here.
module eth_tx_padder
    import eth_pad_pkg::*;
#(
    parameter int PREAMBLE_BITS   = 64,
    parameter int MIN_FRAME_BYTES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_enable,
    input  logic       cfg_pad_en,
    input  logic       cfg_fcs_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);

    localparam int BYTE_BITS   = 8;
    localparam int FCS_BYTES   = 4;
    localparam int IDX_W       = $clog2(FCS_BYTES);
    localparam int THRESH_BITS = PREAMBLE_BITS + (MIN_FRAME_BYTES - FCS_BYTES) * BYTE_BITS;
    localparam int CNT_W       = $clog2(THRESH_BITS + BYTE_BITS + 1);

    pad_state_e       state;
    logic [IDX_W-1:0] fcs_idx;
    logic             reach_next;
    logic             byte_sent;
    logic             frame_done;
    logic [CNT_W-1:0] bit_cnt;
    logic [31:0]      fcs_value;

    eth_pad_ctrl #(
        .FCS_BYTES (FCS_BYTES),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_enable  (tx_enable),
        .cfg_pad_en (cfg_pad_en),
        .cfg_fcs_en (cfg_fcs_en),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .out_ready  (out_ready),
        .reach_next (reach_next),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .byte_sent  (byte_sent),
        .frame_done (frame_done),
        .state      (state),
        .fcs_idx    (fcs_idx)
    );

    eth_pad_bitcnt #(
        .PREAMBLE_BITS (PREAMBLE_BITS),
        .THRESH_BITS   (THRESH_BITS),
        .BYTE_BITS     (BYTE_BITS),
        .CNT_W         (CNT_W)
    ) u_bitcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_sent  (byte_sent),
        .frame_done (frame_done),
        .reach_next (reach_next),
        .bit_cnt    (bit_cnt)
    );

    eth_pad_crc u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_take  (byte_sent),
        .byte_in    (out_data),
        .frame_done (frame_done),
        .fcs_value  (fcs_value)
    );

    // Output byte select: input data, zero pad, or FCS byte (LSB first).
    always_comb begin
        unique case (state)
            ST_DATA: out_data = in_data;
            ST_PAD:  out_data = 8'h00;
            ST_FCS:  out_data = fcs_value[{fcs_idx, 3'b000} +: 8];
            default: out_data = 8'h00;
        endcase
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
    AST_PAD_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FCS && fcs_idx == '0 && $past(state) == ST_PAD)
            |-> (bit_cnt == CNT_W'(THRESH_BITS))); // R2

endmodule

// File: tb/test_eth_tx_padder.sv
// Bench for the transmit auto-pad inserter: directed corner frames plus
// seeded random frames, compared against a model computed from the requirements.
module test_eth_tx_padder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b1;
    logic       cfg_pad_en = 1'b1;
    logic       cfg_fcs_en = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready = 1'b1;

    int total = 0;
    int bad   = 0;

    logic [7:0] fr [0:255];
    int         flen;
    logic [7:0] ex [0:255];
    int         elen;

    always #2.5 clk = ~clk;

    eth_tx_padder i_eth_tx_padder (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_enable  (tx_enable),
        .cfg_pad_en (cfg_pad_en),
        .cfg_fcs_en (cfg_fcs_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_ready  (out_ready)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reflected CRC-32, written from the requirement text (R6).
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, ex[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Expected output: data, zero pad to 544 wire bits, FCS when padded or enabled.
    task automatic build_exp(input bit pad, input bit fcs);
        int  n = flen;
        bit  padded = 0;
        logic [31:0] f;
        for (int i = 0; i < flen; i++) ex[i] = fr[i];
        if (pad) begin
            while (64 + 8 * n < 544) begin
                ex[n] = 8'h00;
                n++;
                padded = 1;
            end
        end
        if (padded || fcs) begin
            f = ref_crc(n);
            for (int j = 0; j < 4; j++) ex[n + j] = f[8*j +: 8];
            n += 4;
        end
        elen = n;
    endtask

    task automatic fill_frame(input int len);
        flen = len;
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic set_cfg(input bit pad, input bit fcs);
        @(negedge clk);
        tx_enable  = 1'b0;
        cfg_pad_en = pad;
        cfg_fcs_en = fcs;
        @(negedge clk);
        @(negedge clk);
        tx_enable = 1'b1;
    endtask

    // Drive one frame with random gaps and stalls; check each output byte.
    task automatic run_frame(input string tag, input int ready_pct);
        int   i = 0;
        int   k = 0;
        int   cyc = 0;
        bit   hold_in = 0;
        bit   pend = 0;
        logic [7:0] pend_d = 8'h00;
        logic pend_l = 1'b0;
        while (k < elen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (!hold_in) in_valid = (i < flen) && ($urandom_range(0, 3) != 0);
            in_data   = fr[i];
            in_last   = (i == flen - 1);
            out_ready = ($urandom_range(0, 99) < ready_pct);
            #1;
            if (pend)
                chk(out_valid && out_data == pend_d && out_last == pend_l,
                    "R9", "held output", {out_last, out_data}, {pend_l, pend_d});
            pend    = out_valid && !out_ready;
            pend_d  = out_data;
            pend_l  = out_last;
            hold_in = in_valid && !in_ready;
            if (in_valid && in_ready) i++;
            if (out_valid && out_ready) begin
                chk(out_data == ex[k] && out_last == (k == elen - 1), tag, "byte",
                    {out_last, out_data}, {(k == elen - 1), ex[k]});
                k++;
            end
        end
        if (cyc >= 3000) chk(0, tag, "frame timeout", k, elen);
        @(negedge clk);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_ready = 1'b1;
        #1;
        chk(!out_valid && i == flen, tag, "no extra output", {out_valid, 8'(i)}, flen);
    endtask

    // Global watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state, configuration off even though the cfg inputs are high
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready, "R1", "in_ready follows out_ready", in_ready, 1);
        fill_frame(5);
        build_exp(0, 0);
        run_frame("R1", 100);

        // R3, R10: one-byte frame padded to the 64-byte minimum
        set_cfg(1, 0);
        fill_frame(1);
        build_exp(1, 1);
        chk(elen == 64 && 64 + 8 * elen == 576, "R10", "model min length", elen, 64);
        run_frame("R3", 80);

        // R2: 59, 60 and 61 data bytes around the threshold
        set_cfg(1, 1);
        fill_frame(59); build_exp(1, 1); run_frame("R2", 75);
        fill_frame(60); build_exp(1, 1); run_frame("R2", 75);
        fill_frame(61); build_exp(1, 1); run_frame("R2", 75);

        // R4: a padded frame gets an FCS while FCS insertion is off
        set_cfg(1, 0);
        fill_frame(20); build_exp(1, 1); run_frame("R4", 90);

        // R5: pass-through with no FCS, with FCS, and with padding off
        fill_frame(60); build_exp(1, 0); run_frame("R5", 90);
        set_cfg(0, 1);
        fill_frame(10); build_exp(0, 1); run_frame("R5", 90);
        set_cfg(0, 0);
        fill_frame(12); build_exp(0, 0); run_frame("R5", 60);

        // R6: FCS bytes and last marker on a long frame
        set_cfg(1, 1);
        fill_frame(80); build_exp(1, 1); run_frame("R6", 70);

        // R8: the length field claims 46 or 1500 bytes; pad count is unchanged
        fill_frame(14); fr[12] = 8'h00; fr[13] = 8'h2E; build_exp(1, 1); run_frame("R8", 80);
        fill_frame(14); fr[12] = 8'h05; fr[13] = 8'hDC; build_exp(1, 1); run_frame("R8", 80);

        // R7: configuration changes while the transmitter is enabled are ignored
        set_cfg(0, 1);
        cfg_pad_en = 1'b1;
        cfg_fcs_en = 1'b0;
        fill_frame(10); build_exp(0, 1); run_frame("R7", 85);

        // R9: heavy back-pressure through padding and FCS
        set_cfg(1, 0);
        fill_frame(3); build_exp(1, 1); run_frame("R9", 30);

        // Random frames with random configuration
        for (int n = 0; n < 24; n++) begin
            bit p = 1'($urandom_range(0, 1));
            bit f = 1'($urandom_range(0, 1));
            set_cfg(p, f);
            fill_frame($urandom_range(1, 90));
            build_exp(p, f);
            run_frame("R2/R5/R6", 70);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule